// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an internal valid/ready request bus and the pins of a 256K x 16 asynchronous static RAM. It accepts one single-word read or write at a time and plays it out as a pin sequence. Each phase is stretched over a parameter-set number of clock cycles, so the memory's minimum access, pulse and setup times are met at the chosen clock rate. Reads come back with a one-cycle response strobe.

The RAM has two selects of opposite polarity, an output enable, a write enable and two active-low byte enables. Between requests the controller deselects the device through both selects and leaves the data bus undriven. A write runs in three phases: setup, write-enable pulse, then hold. The output enable stays high for the whole write, so the controller never drives the data bus while the memory might also be driving it.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held, and in idle, mem_sel_n_o is 1, mem_sel_o is 0, mem_oe_n_o, mem_we_n_o, mem_lb_n_o and mem_ub_n_o are 1, mem_dq_oe_o is 0, req_ready_o is 1 and rsp_valid_o is 0. Reset acts at once, even in the middle of a write.
- R2: A read keeps the device selected with mem_oe_n_o low and mem_we_n_o high for exactly READ_CYC cycles. rsp_valid_o is high for one cycle only, starting on the READ_CYC-th rising edge after the edge that accepted the request.
- R3: req_be_i[0] controls data bits 7:0 and mem_lb_n_o, and req_be_i[1] controls bits 15:8 and mem_ub_n_o; a be bit of 1 means the lane is active. In rsp_rdata_o, an active lane carries mem_dq_i as sampled in the last read cycle, and an inactive lane reads as zero.
- R4: A write first spends WE_SETUP_CYC cycles with the device selected, the byte-enable pins set, mem_we_n_o high and the data bus undriven.
- R5: The write then holds mem_we_n_o low for exactly WE_PULSE_CYC cycles. During that time mem_dq_o carries the write data, mem_dq_oe_o is high and mem_oe_n_o is high.
- R6: After mem_we_n_o rises, select, address, byte enables and driven data are held for HOLD_CYC cycles. The device is then released, and req_ready_o returns on the rising edge WE_SETUP_CYC+WE_PULSE_CYC+HOLD_CYC edges after acceptance.
- R7: mem_dq_oe_o is never high while mem_oe_n_o is low.
- R8: req_ready_o is low from the edge that accepts a request until that request finishes, so only one request is outstanding.
- R9: A request with req_be_i = 00 asserts neither byte-enable pin. Such a write leaves the memory contents unchanged, and such a read returns zero.
- R10: mem_addr_o equals the accepted req_addr_i for every cycle of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane enables, 1 = active |
| rsp_valid_o | output | 1 | Read data valid strobe |
| rsp_rdata_o | output | 16 | Read data, inactive lanes zero |
| mem_addr_o | output | 18 | Memory address pins |
| mem_dq_o | output | 16 | Data to the memory |
| mem_dq_oe_o | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory |
| mem_sel_n_o | output | 1 | Active-low device select |
| mem_sel_o | output | 1 | Active-high device select |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_lb_n_o | output | 1 | Lower byte enable, active low |
| mem_ub_n_o | output | 1 | Upper byte enable, active low |

## Verification
The hardest case to reach is a partial-lane write that must merge with earlier contents, followed by a read that masks lanes. Reaching it takes a full write, then a single-lane write to the same word, then reads with each lane mask. The bench walks such a sequence against a behavioural memory. That memory commits data only on the rising edge of the write enable, and only for lanes whose pins are low. It drives junk patterns on lanes that are disabled or not being read, so a missing mask shows up in the returned data. A reset dropped in the middle of a write pulse covers the abort path, which ordinary traffic never reaches.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } phase_e;
endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int READ_CYC     = 5,
  parameter int WE_SETUP_CYC = 1,
  parameter int WE_PULSE_CYC = 4,
  parameter int HOLD_CYC     = 1,
  parameter int CNT_W        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             we_i,
  input  logic             done_i,
  output phase_e           phase_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);
  localparam logic [CNT_W-1:0] RD_LEN = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] SU_LEN = CNT_W'(WE_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PW_LEN = CNT_W'(WE_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HD_LEN = CNT_W'(HOLD_CYC - 1);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d    = phase_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (phase_q)
      ST_IDLE: if (start_i) begin
        phase_d    = we_i ? ST_WSETUP : ST_READ;
        load_o     = 1'b1;
        load_val_o = we_i ? SU_LEN : RD_LEN;
      end
      ST_READ:   if (done_i) phase_d = ST_IDLE;
      ST_WSETUP: if (done_i) begin
        phase_d    = ST_WPULSE;
        load_o     = 1'b1;
        load_val_o = PW_LEN;
      end
      ST_WPULSE: if (done_i) begin
        phase_d    = ST_WHOLD;
        load_o     = 1'b1;
        load_val_o = HD_LEN;
      end
      ST_WHOLD:  if (done_i) phase_d = ST_IDLE;
      default:   phase_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= ST_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R5
  pulse_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_WPULSE) |-> ($past(phase_q) == ST_WSETUP || $past(phase_q) == ST_WPULSE));

  // R6
  hold_after_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_WHOLD) |-> ($past(phase_q) == ST_WPULSE || $past(phase_q) == ST_WHOLD));
endmodule

// File: rtl/asram_lane.sv
module asram_lane (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       busy_i,
  input  logic       cap_i,
  input  logic [7:0] din_i,
  output logic       bsel_n_o,
  output logic [7:0] rdata_o
);
  assign bsel_n_o = !(busy_i && en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= en_i ? din_i : 8'h00;
  end

  // R3
  off_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !en_i) |=> (rdata_o == 8'h00));
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int READ_CYC     = 5,
  parameter int WE_SETUP_CYC = 1,
  parameter int WE_PULSE_CYC = 4,
  parameter int HOLD_CYC     = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_be_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_sel_n_o,
  output logic              mem_sel_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic              mem_lb_n_o,
  output logic              mem_ub_n_o
);
  localparam int MAX_A   = (READ_CYC > WE_SETUP_CYC) ? READ_CYC : WE_SETUP_CYC;
  localparam int MAX_B   = (WE_PULSE_CYC > HOLD_CYC) ? WE_PULSE_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_e             phase;
  logic               load, done, busy, start, last_rd;
  logic [CNT_W-1:0]   load_val;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   be_q, bsel_n;

  assign busy    = (phase != ST_IDLE);
  assign start   = req_valid_i && !busy;
  assign last_rd = (phase == ST_READ) && done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_o <= 1'b0;
    else         rsp_valid_o <= last_rd;
  end

  asram_seq #(
    .READ_CYC(READ_CYC), .WE_SETUP_CYC(WE_SETUP_CYC),
    .WE_PULSE_CYC(WE_PULSE_CYC), .HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .we_i(req_we_i),
    .done_i(done), .phase_o(phase), .load_o(load), .load_val_o(load_val)
  );

  asram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .load_val_i(load_val), .done_o(done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    asram_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(be_q[l]), .busy_i(busy),
      .cap_i(last_rd), .din_i(mem_dq_i[l*8 +: 8]),
      .bsel_n_o(bsel_n[l]), .rdata_o(rsp_rdata_o[l*8 +: 8])
    );
  end

  assign req_ready_o = !busy;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = (phase == ST_WPULSE) || (phase == ST_WHOLD);
  assign mem_sel_n_o = !busy;
  assign mem_sel_o   = busy;
  assign mem_oe_n_o  = (phase != ST_READ);
  assign mem_we_n_o  = (phase != ST_WPULSE);
  assign mem_lb_n_o  = bsel_n[0];
  assign mem_ub_n_o  = bsel_n[LANES-1];

  // R7
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  // R5
  we_low_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_dq_oe_o && !mem_sel_n_o && mem_sel_o));

  // R4
  we_fall_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> ($past(!mem_sel_n_o) && $past(!mem_dq_oe_o)));

  // R8
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R2
  rsp_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(!mem_oe_n_o) && mem_oe_n_o));

  // R10
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> $stable(mem_addr_o));
endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;
  localparam int RD = 5, SU = 1, PW = 4, HD = 1;
  localparam int NV = 14;
  // {we, addr[17:0], wdata[15:0], be[1:0], expected rdata[15:0]}
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 18'h00003, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 18'h3FFC5, 16'hABCD, 2'b11, 16'h0000},
    {1'b1, 18'h2003A, 16'h5555, 2'b11, 16'h0000},
    {1'b0, 18'h00003, 16'h0000, 2'b11, 16'h1234},
    {1'b0, 18'h3FFC5, 16'h0000, 2'b01, 16'h00CD},
    {1'b0, 18'h3FFC5, 16'h0000, 2'b10, 16'hAB00},
    {1'b1, 18'h00003, 16'hFFEE, 2'b01, 16'h0000},
    {1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12EE},
    {1'b1, 18'h3FFC5, 16'h7788, 2'b10, 16'h0000},
    {1'b0, 18'h3FFC5, 16'h0000, 2'b11, 16'h77CD},
    {1'b1, 18'h00003, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12EE},
    {1'b0, 18'h00003, 16'h0000, 2'b00, 16'h0000},
    {1'b0, 18'h2003A, 16'h0000, 2'b11, 16'h5555}
  };

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [17:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_be_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_dq_oe_o;
  logic [15:0] rsp_rdata_o, mem_dq_o, mem_dq_i;
  logic [17:0] mem_addr_o;
  logic        mem_sel_n_o, mem_sel_o, mem_oe_n_o, mem_we_n_o, mem_lb_n_o, mem_ub_n_o;

  asram_ctrl #(.READ_CYC(RD), .WE_SETUP_CYC(SU), .WE_PULSE_CYC(PW), .HOLD_CYC(HD)) u_asram_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_we_i, .req_addr_i,
    .req_wdata_i, .req_be_i, .rsp_valid_o, .rsp_rdata_o, .mem_addr_o,
    .mem_dq_o, .mem_dq_oe_o, .mem_dq_i, .mem_sel_n_o, .mem_sel_o,
    .mem_oe_n_o, .mem_we_n_o, .mem_lb_n_o, .mem_ub_n_o
  );

  // behavioural memory: commits on the rising edge of write enable
  logic [15:0] mdl [64];
  logic        dev_on;
  assign dev_on = (mem_sel_n_o === 1'b0) && (mem_sel_o === 1'b1);
  always @(posedge mem_we_n_o) begin
    if (dev_on) begin
      if (!mem_lb_n_o) mdl[mem_addr_o[5:0]][7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n_o) mdl[mem_addr_o[5:0]][15:8] = mem_dq_o[15:8];
    end
  end
  assign mem_dq_i = (dev_on && !mem_oe_n_o && mem_we_n_o) ?
    {mem_ub_n_o ? 8'hA5 : mdl[mem_addr_o[5:0]][15:8],
     mem_lb_n_o ? 8'h5A : mdl[mem_addr_o[5:0]][7:0]} : 16'hC3C3;

  int n_chk = 0, n_bad = 0;
  bit fin = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_pins(input string tag);
    chk({tag, " sel_n"}, 32'(mem_sel_n_o), 1);
    chk({tag, " sel"},   32'(mem_sel_o), 0);
    chk({tag, " ctl"},   32'({mem_oe_n_o, mem_we_n_o, mem_lb_n_o, mem_ub_n_o}), 32'hF);
    chk({tag, " dq_oe"}, 32'(mem_dq_oe_o), 0);
  endtask

  task automatic run(input logic we, input logic [17:0] a, input logic [15:0] d,
                     input logic [1:0] be, input logic [15:0] exp);
    int cyc = 0, pw = 0, su = 0, hd = 0, oe_lo = 0;
    int adr_bad = 0, pin_bad = 0, dat_bad = 0, rdy_bad = 0, fight = 0;
    while (!req_ready_o) @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_be_i = be;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = ~a; req_wdata_i = ~d; req_be_i = ~be;
    forever begin
      if (we ? req_ready_o : rsp_valid_o) break;
      cyc++;
      if (req_ready_o) rdy_bad++;
      if (mem_addr_o !== a) adr_bad++;
      if (mem_sel_n_o !== 1'b0 || mem_sel_o !== 1'b1 ||
          mem_lb_n_o !== !be[0] || mem_ub_n_o !== !be[1]) pin_bad++;
      if (mem_dq_oe_o && !mem_oe_n_o) fight++;
      if (!mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o) oe_lo++;
      if (!mem_we_n_o) begin
        pw++;
        if (!mem_dq_oe_o || mem_dq_o !== d || !mem_oe_n_o) dat_bad++;
      end else if (mem_dq_oe_o) begin
        hd++;
        if (mem_dq_o !== d) dat_bad++;
      end else if (mem_oe_n_o) su++;
      if (cyc > 50) break;
      @(negedge clk_i);
    end
    chk("R10 addr held", 32'(adr_bad), 0);
    chk("R8 ready low while busy", 32'(rdy_bad), 0);
    chk("R7 no bus fight", 32'(fight), 0);
    chk("R3/R9 select and lane pins", 32'(pin_bad), 0);
    if (we) begin
      chk("R6 write length", 32'(cyc), SU + PW + HD);
      chk("R4 setup cycles", 32'(su), SU);
      chk("R5 pulse cycles", 32'(pw), PW);
      chk("R6 hold cycles", 32'(hd), HD);
      chk("R5 data driven", 32'(dat_bad), 0);
    end else begin
      chk("R2 read latency", 32'(cyc), RD);
      chk("R2 oe low cycles", 32'(oe_lo), RD);
      chk("R3 read data", 32'(rsp_rdata_o), 32'(exp));
      @(negedge clk_i);
      chk("R2 single strobe", 32'(rsp_valid_o), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 16'h0000;
    #1;
    // R1 reset state
    idle_pins("R1 in reset");
    chk("R1 ready", 32'(req_ready_o), 1);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_pins("R1 idle");

    for (int i = 0; i < NV; i++)
      run(VEC[i][52], VEC[i][51:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0]);
    idle_pins("R1 idle after traffic");

    // R1 reset in the middle of a write pulse: pins drop at once, word untouched
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = 18'h00003;
    req_wdata_i = 16'h0BAD; req_be_i = 2'b11;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R5 pulse active before abort", 32'(mem_we_n_o), 0);
    rst_ni = 1'b0;
    #1;
    idle_pins("R1 async reset");
    chk("R1 ready after abort", 32'(req_ready_o), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12EE);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule